// File: doc/BRIEF.md
# Trigger-Controlled Up-Counter with Slave Modes

This block is an up-counting timer core. Its counting is started, stopped, gated and cleared by a trigger input, according to a 3-bit slave mode. The modes cover free running, clear on trigger, gating by trigger level, start on trigger, and two combinations: clear-and-start, and gate-with-clear-on-release.

The counter normally advances once per internal clock. When the external clock option is set, it instead advances on the active edge of a second input, and the trigger still selects when counting is allowed. Both inputs pass through a two-stage synchroniser before any edge or level is used.

The counter wraps to zero after reaching the reload value, and each wrap produces a one-cycle update pulse. The mode field can be double-buffered: a new value is held in a shadow register until the next wrap. A sticky flag records trigger edges that enable counting.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: After reset the count is 0, the update output is 0, the trigger flag is 0 and the active mode is 000.
- R2: In mode 000 with the external clock off, the count rises by one every clock. When the count equals the reload value, the next step sets it to 0, and update_o is 1 for exactly that cycle.
- R3: In mode 100 a trigger rising edge sets the count to 0 and pulses update_o for one cycle. Counting then carries on.
- R4: In mode 101 the count advances only while the synchronised trigger is high, and it holds its value while the trigger is low.
- R5: In mode 110 the count holds until a trigger rising edge. After that edge it counts on every tick and keeps counting when the trigger falls, until the mode changes.
- R6: In mode 111 a trigger rising edge sets the count to 0, pulses update_o and starts counting.
- R7: In mode 001 the count advances while the trigger is high. When the trigger falls, the count is set to 0 and stops, and no update pulse is produced.
- R8: When ext_clk_en is 1, a tick is an active edge of ext_clk_in: the rising edge when ext_pol is 0 and the falling edge when ext_pol is 1. This works together with any mode, including mode 110.
- R9: A change on trig_in or ext_clk_in sampled at clock edge n acts on the count at clock edge n+2.
- R10: A trigger rising edge in mode 101, 110, 111 or 001 sets trig_flag_o, and it stays set. Modes 000 and 100 leave the flag untouched. Writing flag_wdata=0 with flag_wr clears the flag, and a set in the same cycle takes priority over the clear.
- R11: With mode_pre_en=1, a mode write goes to a shadow register and becomes active only at a counter wrap. With mode_pre_en=0, the write takes effect at once.
- R12: The unused codes 010 and 011 behave like mode 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode value to write |
| mode_pre_en | input | 1 | Route mode writes through the shadow register |
| ext_clk_en | input | 1 | Count on external clock edges |
| ext_pol | input | 1 | External edge select: 0 rising, 1 falling |
| reload | input | W | Wrap value of the counter |
| flag_wr | input | 1 | Trigger flag write strobe |
| flag_wdata | input | 1 | Trigger flag write data (0 clears) |
| trig_in | input | 1 | Trigger input (asynchronous) |
| ext_clk_in | input | 1 | External clock input (asynchronous) |
| count_o | output | W | Counter value |
| update_o | output | 1 | One-cycle update event |
| trig_flag_o | output | 1 | Sticky trigger flag |

## Verification
The hardest cases to reach are the ones whose effect depends on internal state that cannot be seen: a preloaded mode that is still waiting for a wrap, and a start latch that must be cleared before mode 111 can be tested. The stimulus sets these up through mode sequences. First, a preloaded change from free running to trigger mode is observed as the count continuing to climb until the wrap and then freezing at zero. Second, a pass through mode 000 clears the start latch before mode 111 is entered. A flag clear is timed to land in the same cycle as the synchronised trigger edge, which checks that the set wins.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_FREE     = 3'b000;
    localparam logic [MODE_W-1:0] MODE_GATE_RST = 3'b001;
    localparam logic [MODE_W-1:0] MODE_RST      = 3'b100;
    localparam logic [MODE_W-1:0] MODE_GATE     = 3'b101;
    localparam logic [MODE_W-1:0] MODE_TRIG     = 3'b110;
    localparam logic [MODE_W-1:0] MODE_RST_TRIG = 3'b111;
endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic pol,
    output logic lvl,
    output logic act,
    output logic inact
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } state_t;

    state_t st_d, st_q;
    logic   rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl   = st_q.sync[STAGES-1];
    assign rise  = lvl & ~st_q.prev;
    assign fall  = ~lvl & st_q.prev;
    assign act   = pol ? fall : rise;
    assign inact = pol ? rise : fall;
endmodule

// File: rtl/tsc_mode_reg.sv
module tsc_mode_reg
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              pre_en,
    input  logic              ovf,
    output logic [MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic [MODE_W-1:0] shadow;
        logic [MODE_W-1:0] active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovf && pre_en) st_d.active = st_q.shadow;
        if (wr) begin
            st_d.shadow = wdata;
            if (!pre_en) st_d.active = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{shadow: MODE_FREE, active: MODE_FREE};
        else        st_q <= st_d;
    end

    assign mode_o = st_q.active;
endmodule

// File: rtl/tsc_count_core.sv
module tsc_count_core
    import tsc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              tick_src,
    input  logic              trg_lvl,
    input  logic              trg_rise,
    input  logic              trg_fall,
    input  logic [W-1:0]      reload,
    input  logic              flag_clr,
    output logic [W-1:0]      count_o,
    output logic              update_o,
    output logic              flag_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         upd;
        logic         run;
        logic         flag;
    } state_t;

    state_t st_d, st_q;
    logic   en, clr, trg_upd, flag_set, starts, gates;

    always_comb begin
        starts   = (mode == MODE_TRIG) || (mode == MODE_RST_TRIG);
        gates    = (mode == MODE_GATE) || (mode == MODE_GATE_RST);
        en       = starts ? st_q.run : (gates ? trg_lvl : 1'b1);
        trg_upd  = ((mode == MODE_RST) || (mode == MODE_RST_TRIG)) && trg_rise;
        clr      = trg_upd || ((mode == MODE_GATE_RST) && trg_fall);
        flag_set = (starts || gates) && trg_rise;
        ovf_o    = 1'b0;

        st_d      = st_q;
        st_d.upd  = trg_upd;
        st_d.run  = starts && (st_q.run || trg_rise);
        st_d.flag = flag_set || (st_q.flag && !flag_clr);
        if (clr) begin
            st_d.cnt = '0;
        end else if (en && tick_src) begin
            if (st_q.cnt == reload) begin
                st_d.cnt = '0;
                st_d.upd = 1'b1;
                ovf_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o  = st_q.cnt;
    assign update_o = st_q.upd;
    assign flag_o   = st_q.flag;
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tsc_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic [2:0]   mode_wdata,
    input  logic         mode_pre_en,
    input  logic         ext_clk_en,
    input  logic         ext_pol,
    input  logic [W-1:0] reload,
    input  logic         flag_wr,
    input  logic         flag_wdata,
    input  logic         trig_in,
    input  logic         ext_clk_in,
    output logic [W-1:0] count_o,
    output logic         update_o,
    output logic         trig_flag_o
);
    logic              trg_lvl, trg_rise, trg_fall;
    logic              ext_lvl, ext_act, ext_inact;
    logic              ext_unused;
    logic              ovf, tick_src, flag_clr;
    logic [MODE_W-1:0] act_mode;

    tsc_edge_sync #(.STAGES(SYNC_STAGES)) u_trg_sync (
        .clk(clk), .rst_n(rst_n), .din(trig_in), .pol(1'b0),
        .lvl(trg_lvl), .act(trg_rise), .inact(trg_fall)
    );

    tsc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .pol(ext_pol),
        .lvl(ext_lvl), .act(ext_act), .inact(ext_inact)
    );

    assign ext_unused = ext_lvl ^ ext_inact;
    assign tick_src   = ext_clk_en ? ext_act : 1'b1;
    assign flag_clr   = flag_wr && !flag_wdata;

    tsc_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(mode_wdata),
        .pre_en(mode_pre_en), .ovf(ovf), .mode_o(act_mode)
    );

    tsc_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(act_mode), .tick_src(tick_src),
        .trg_lvl(trg_lvl), .trg_rise(trg_rise), .trg_fall(trg_fall),
        .reload(reload), .flag_clr(flag_clr), .count_o(count_o),
        .update_o(update_o), .flag_o(trig_flag_o), .ovf_o(ovf)
    );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] count_o,
    input logic         update_o,
    input logic         trig_flag_o,
    input logic         flag_wr,
    input logic         flag_wdata,
    input logic [W-1:0] reload,
    input logic [2:0]   act_mode,
    input logic         trg_lvl
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == W'($past(count_o) + 1'b1) || count_o == '0)); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(reload) && $past(count_o) <= reload) |-> (count_o <= reload)); // R2

    AST_UPDATE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (count_o == '0)); // R3

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 3'b101 && !trg_lvl) |=> $stable(count_o)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag_o && !(flag_wr && !flag_wdata)) |=> trig_flag_o); // R10
endmodule

bind tmr_slave_ctrl tsc_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count_o(count_o), .update_o(update_o),
    .trig_flag_o(trig_flag_o), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .reload(reload), .act_mode(act_mode), .trg_lvl(trg_lvl)
);

// File: tb/test_tmr_slave_ctrl.sv
module test_tmr_slave_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_wr = 1'b0;
    logic [2:0]   mode_wdata = 3'b000;
    logic         mode_pre_en = 1'b0;
    logic         ext_clk_en = 1'b0;
    logic         ext_pol = 1'b0;
    logic [W-1:0] reload = 8'd3;
    logic         flag_wr = 1'b0;
    logic         flag_wdata = 1'b0;
    logic         trig_in = 1'b0;
    logic         ext_clk_in = 1'b0;
    logic [W-1:0] count_o;
    logic         update_o;
    logic         trig_flag_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tmr_slave_ctrl #(.W(W)) i_tmr_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_pre_en(mode_pre_en), .ext_clk_en(ext_clk_en), .ext_pol(ext_pol),
        .reload(reload), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .trig_in(trig_in), .ext_clk_in(ext_clk_in), .count_o(count_o),
        .update_o(update_o), .trig_flag_o(trig_flag_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [2:0] m);
        mode_wdata = m;
        mode_wr    = 1'b1;
        step(1);
        mode_wr    = 1'b0;
    endtask

    task automatic clear_flag();
        flag_wdata = 1'b0;
        flag_wr    = 1'b1;
        step(1);
        flag_wr    = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(2);
        check("R1 count", int'(count_o), 0);
        check("R1 update", int'(update_o), 0);
        check("R1 flag", int'(trig_flag_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_free();
        int exp;
        step(1);
        exp = int'(count_o);
        for (int i = 0; i < 9; i++) begin
            step(1);
            exp = (exp + 1) % 4;
            check("R2 count", int'(count_o), exp);
            check("R2 update", int'(update_o), (exp == 0) ? 1 : 0);
        end
    endtask

    task automatic t_reset_mode();
        reload = 8'd255;
        write_mode(3'b100);
        trig_in = 1'b1;
        step(3);
        check("R3 cleared", int'(count_o), 0);
        check("R3 update", int'(update_o), 1);
        step(1);
        check("R3 continues", int'(count_o), 1);
        check("R3 pulse width", int'(update_o), 0);
        check("R10 no flag in 100", int'(trig_flag_o), 0);
        trig_in = 1'b0;
        step(4);
    endtask

    task automatic t_gated();
        int c;
        write_mode(3'b101);
        c = int'(count_o);
        step(3);
        check("R4 hold low", int'(count_o), c);
        trig_in = 1'b1;
        step(2);
        check("R9 no effect yet", int'(count_o), c);
        step(1);
        check("R9 effect at n+2", int'(count_o), c + 1);
        step(4);
        check("R4 counts high", int'(count_o), c + 5);
        trig_in = 1'b0;
        step(3);
        check("R4 stops", int'(count_o), c + 7);
        step(3);
        check("R4 holds", int'(count_o), c + 7);
        check("R10 flag in 101", int'(trig_flag_o), 1);
        clear_flag();
        check("R10 cleared", int'(trig_flag_o), 0);
    endtask

    task automatic t_trigger();
        int c;
        write_mode(3'b110);
        c = int'(count_o);
        step(5);
        check("R5 idle", int'(count_o), c);
        trig_in = 1'b1;
        step(3);
        check("R5 start latency", int'(count_o), c);
        step(1);
        check("R5 started", int'(count_o), c + 1);
        trig_in = 1'b0;
        step(8);
        check("R5 runs after fall", int'(count_o), c + 9);
        check("R10 flag in 110", int'(trig_flag_o), 1);
        flag_wdata = 1'b1;
        flag_wr    = 1'b1;
        step(1);
        flag_wr    = 1'b0;
        check("R10 write 1 keeps", int'(trig_flag_o), 1);
        clear_flag();
    endtask

    task automatic t_rst_trig();
        int c;
        write_mode(3'b000);
        write_mode(3'b111);
        c = int'(count_o);
        step(3);
        check("R6 idle", int'(count_o), c);
        trig_in = 1'b1;
        step(2);
        flag_wdata = 1'b0;
        flag_wr    = 1'b1;
        step(1);
        flag_wr    = 1'b0;
        check("R6 cleared", int'(count_o), 0);
        check("R6 update", int'(update_o), 1);
        check("R10 set wins", int'(trig_flag_o), 1);
        step(1);
        check("R6 started", int'(count_o), 1);
        step(3);
        check("R6 counting", int'(count_o), 4);
        trig_in = 1'b0;
        step(4);
    endtask

    task automatic t_gate_rst();
        int c;
        write_mode(3'b001);
        c = int'(count_o);
        step(3);
        check("R7 hold low", int'(count_o), c);
        trig_in = 1'b1;
        step(3);
        check("R7 counts", int'(count_o), c + 1);
        step(3);
        check("R7 counts more", int'(count_o), c + 4);
        trig_in = 1'b0;
        step(3);
        check("R7 cleared on fall", int'(count_o), 0);
        check("R7 no update", int'(update_o), 0);
        step(3);
        check("R7 stays 0", int'(count_o), 0);
    endtask

    task automatic t_ext();
        int c;
        ext_clk_en = 1'b1;
        ext_pol    = 1'b0;
        write_mode(3'b000);
        c = int'(count_o);
        step(3);
        check("R8 no edges", int'(count_o), c);
        ext_clk_in = 1'b1;
        step(3);
        check("R8 rising counts", int'(count_o), c + 1);
        ext_clk_in = 1'b0;
        step(3);
        check("R8 falling ignored", int'(count_o), c + 1);
        ext_pol = 1'b1;
        ext_clk_in = 1'b1;
        step(3);
        check("R8 rising ignored pol1", int'(count_o), c + 1);
        ext_clk_in = 1'b0;
        step(3);
        check("R8 falling counts pol1", int'(count_o), c + 2);
        clear_flag();
        write_mode(3'b110);
        trig_in = 1'b1;
        step(4);
        check("R8 trigger no edges", int'(count_o), c + 2);
        check("R10 flag ext trig", int'(trig_flag_o), 1);
        ext_clk_in = 1'b1;
        step(3);
        ext_clk_in = 1'b0;
        step(3);
        check("R8 ext in trigger mode", int'(count_o), c + 3);
        trig_in    = 1'b0;
        ext_clk_en = 1'b0;
        ext_pol    = 1'b0;
        step(4);
    endtask

    task automatic t_preload();
        int prev;
        bit wrapped;
        reload = 8'd7;
        write_mode(3'b000);
        step(1);
        if (int'(count_o) > 7) begin
            write_mode(3'b100);
            trig_in = 1'b1;
            step(4);
            trig_in = 1'b0;
            write_mode(3'b000);
        end
        mode_pre_en = 1'b1;
        write_mode(3'b110);
        prev = int'(count_o);
        wrapped = 1'b0;
        for (int i = 0; i < 12 && !wrapped; i++) begin
            step(1);
            if (count_o == 0) begin
                wrapped = 1'b1;
                check("R11 wrap from 7", prev, 7);
                check("R11 wrap update", int'(update_o), 1);
            end else begin
                check("R11 still old mode", int'(count_o), prev + 1);
                prev = int'(count_o);
            end
        end
        check("R11 wrap seen", int'(wrapped), 1);
        step(5);
        check("R11 new mode after wrap", int'(count_o), 0);
        mode_pre_en = 1'b0;
        write_mode(3'b000);
        step(1);
        check("R11 direct write", int'(count_o), 1);
    endtask

    task automatic t_unused();
        int c;
        write_mode(3'b010);
        c = int'(count_o);
        step(3);
        check("R12 code 010", int'(count_o), (c + 3) % 8);
        write_mode(3'b011);
        c = int'(count_o);
        step(2);
        check("R12 code 011", int'(count_o), (c + 2) % 8);
    endtask

    initial begin
        step(1);
        t_reset();
        t_free();
        t_reset_mode();
        t_gated();
        t_trigger();
        t_rst_trig();
        t_gate_rst();
        t_ext();
        t_preload();
        t_unused();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule